// File: doc/BRIEF.md
# Buffered Serial Frame Transmitter

This block is the transmit half of an asynchronous serial port. It turns bytes that a processor writes into framed bits on one serial line: a low start bit, 8 or 9 data bits sent least significant bit first, and a high stop bit. A one-word holding register sits in front of the shift register. While one frame is on the line, the next word can be written and it follows with no gap. Bit timing comes from an external `bit_tick` strobe, so each bit lasts one tick period. The baud generator, the receiver and the interrupt controller are all outside this block.

The same engine also sends line conditions. Turning the transmit enable on queues an idle frame, which is all ones and as long as a data frame. Holding the break control high sends all-zero break frames back to back. In a bus-master mode the break is stretched to 13 bit times. When a break ends, one high bit is inserted so that the next start edge can be detected.

Two flags report the state of the transmitter: a buffer-empty flag and a frame-done flag. Each drives an interrupt request through its own enable. The flags clear only through a status read followed by a data write, the usual protected clearing sequence.

Top module: `sertx_engine`

## Requirements
- R1: A clock edge with `rst_n` low drives `tx_out` to 1, sets `flag_empty` and `flag_done` to 1, and drops any queued or in-flight frame.
- R2: With `cfg_nine`=0, a data frame is a 0 start bit, then the 8 bits of the word with bit 0 first, then a 1 stop bit. Each bit is held for exactly one `bit_tick` period. The first bit begins at the first tick after the frame is loaded, and the line returns to 1 at the tick that ends the frame.
- R3: With `cfg_nine`=1, the frame carries a ninth data bit placed just before the stop bit. Its value is `cfg_bit9` as sampled when the frame is loaded. The frame lasts 11 bit times.
- R4: A write made while transmission is enabled, no frame is on the line and nothing is queued loads the written word straight into the shift register, and `flag_empty` stays 1.
- R5: A write made during a frame goes to the holding register. That word starts at the tick that ends the current frame, with no idle bit between the two frames, and `flag_empty` returns to 1 when the word moves.
- R6: A write clears `flag_done`, and also clears `flag_empty` when the word lands in the holding register, only if a `stat_rd` pulse came after the previous write. Without such a pulse both flags keep their values.
- R7: `flag_done` is set at the tick that ends any frame: data, idle, break or inserted mark bit. `irq_empty` equals `flag_empty` AND `cfg_empty_ie`, and `irq_done` equals `flag_done` AND `cfg_done_ie`.
- R8: While `cfg_brk` is 1 and transmission is enabled, all-zero break frames follow one another with no gap. Each lasts 10 bit times with `cfg_nine`=0 and 11 with `cfg_nine`=1. A break takes precedence over a held word.
- R9: A break frame that ends while `cfg_brk` is 0 is followed by exactly one 1 bit before any other frame starts.
- R10: With `cfg_lin`=1, every break frame lasts 13 zero bit times, whatever the value of `cfg_nine`.
- R11: A 0-to-1 change of `cfg_tx_en` queues one idle frame (all ones, 10 or 11 bit times). That frame goes out before any data, after the current frame if one is in progress. The same change empties the holding register, which sets `flag_empty` to 1.
- R12: While `cfg_tx_en` is 0, no new frame starts. A frame already on the line completes, and written words wait in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe marking each bit boundary |
| stat_rd | input | 1 | Status register read strobe; arms flag clearing |
| data_wr | input | 1 | Data register write strobe |
| wr_byte | input | DATA_W | Word being written |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_bit9 | input | 1 | Value of the ninth data bit |
| cfg_tx_en | input | 1 | Transmit enable; a rising edge queues an idle frame |
| cfg_brk | input | 1 | Send break frames while high |
| cfg_lin | input | 1 | Bus-master mode: 13-bit breaks |
| cfg_empty_ie | input | 1 | Interrupt enable for the buffer-empty flag |
| cfg_done_ie | input | 1 | Interrupt enable for the frame-done flag |
| tx_out | output | 1 | Serial line, idles high |
| flag_empty | output | 1 | Holding register may be written |
| flag_done | output | 1 | A frame has ended |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Frame-done interrupt request |

## Verification
The hardest conditions to reach from the ports are hand-overs that happen at a frame boundary while other stimulus is still pending. One case is a word held behind a break, which must wait for the inserted mark bit once the break control drops. Another is an enable toggle in mid-frame, which has to throw away the held word and queue an idle frame instead. The bench reaches both by running a tick-aligned line capture in parallel with the control changes. Writes and control edges land a few cycles into a frame, well before the boundary at which the engine picks its next frame, so one capture records the whole sequence of frames and gaps.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmit engine.
// Assumes: a single clock domain; consumers import the package.
package sertx_pkg;

    // What the shift register is currently sending
    typedef enum logic [2:0] {
        K_NONE,
        K_DATA,
        K_IDLE,
        K_BRK,
        K_MARK
    } kind_t;

    // Which source feeds the shift register at the next load opportunity
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_MARK,
        SRC_IDLE,
        SRC_BRK,
        SRC_HOLD,
        SRC_DIRECT
    } src_t;

endpackage

// File: rtl/sertx_holdq.sv
// Holding register, enable-edge detector and pending-idle request.
// Assumes: wr_buf is already qualified (write not consumed directly);
// a write in the same cycle as an enable rise survives the discard.
module sertx_holdq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te,
    input  logic              wr_buf,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold_taken,
    input  logic              idle_taken,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              te_rise,
    output logic              idle_pend
);
    logic te_q;
    logic idle_req_q;
    logic full_q;
    logic [DATA_W-1:0] data_q;

    assign te_rise   = te && !te_q;
    assign idle_pend = idle_req_q || te_rise;
    assign full      = full_q;
    assign data      = data_q;

    // Remember the previous enable level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) te_q <= 1'b0;
        else        te_q <= te;
    end

    // Keep an idle request until the shifter consumes it
    always_ff @(posedge clk) begin
        if (!rst_n)          idle_req_q <= 1'b0;
        else if (idle_taken) idle_req_q <= 1'b0;
        else if (te_rise)    idle_req_q <= 1'b1;
    end

    // Holding register: fill on write, empty on transfer or enable rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (wr_buf) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end else if (hold_taken || te_rise) begin
            full_q <= 1'b0;
        end
    end

    // R11: an enable rise without a same-cycle write leaves the buffer empty
    p_discard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        te_rise && !wr_buf |=> !full_q);

endmodule

// File: rtl/sertx_frame_pick.sv
// Chooses the next frame and builds its bit pattern, LSB sent first.
// Assumes: the result is only consumed when the shifter is idle or at
// the tick that ends its frame. Priority: mark after break, idle, break,
// held word, direct write.
module sertx_frame_pick
    import sertx_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int LIN_BRK_BITS = 13,
    parameter int FW           = 13,
    parameter int CNT_W        = 4
) (
    input  logic              te_en,
    input  logic              busy,
    input  kind_t             cur_kind,
    input  logic              brk,
    input  logic              lin,
    input  logic              m9,
    input  logic              t8,
    input  logic              idle_pend,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output src_t              src,
    output logic              nxt_valid,
    output logic [FW-1:0]     nxt_bits,
    output logic [CNT_W-1:0]  nxt_len,
    output kind_t             nxt_kind
);
    logic [DATA_W-1:0] data_sel;
    logic [FW-1:0]     data_bits;
    logic [CNT_W-1:0]  word_len;

    assign data_sel = hold_full ? hold_data : wr_data;
    assign word_len = CNT_W'(DATA_W + 2) + CNT_W'(m9);

    // Data frame layout: start, data bits, optional ninth bit, stop and fill
    assign data_bits[0] = 1'b0;
    for (genvar g = 0; g < DATA_W; g++) begin : g_data_bit
        assign data_bits[g+1] = data_sel[g];
    end
    assign data_bits[DATA_W+1] = m9 ? t8 : 1'b1;
    if (FW > DATA_W + 2) begin : g_fill
        assign data_bits[FW-1:DATA_W+2] = '1;
    end

    // Priority selection of the next frame source
    always_comb begin
        src = SRC_NONE;
        if (busy && cur_kind == K_BRK && !brk) begin
            src = SRC_MARK;
        end else if (te_en) begin
            if (idle_pend)         src = SRC_IDLE;
            else if (brk)          src = SRC_BRK;
            else if (hold_full)    src = SRC_HOLD;
            else if (wr && !busy)  src = SRC_DIRECT;
        end
    end

    // Pattern, length and kind for the chosen source
    always_comb begin
        nxt_bits = '1;
        nxt_len  = '0;
        nxt_kind = K_NONE;
        case (src)
            SRC_MARK: begin
                nxt_len  = CNT_W'(1);
                nxt_kind = K_MARK;
            end
            SRC_IDLE: begin
                nxt_len  = word_len;
                nxt_kind = K_IDLE;
            end
            SRC_BRK: begin
                nxt_bits = '0;
                nxt_len  = lin ? CNT_W'(LIN_BRK_BITS) : word_len;
                nxt_kind = K_BRK;
            end
            SRC_HOLD, SRC_DIRECT: begin
                nxt_bits = data_bits;
                nxt_len  = word_len;
                nxt_kind = K_DATA;
            end
            default: ;
        endcase
    end

    assign nxt_valid = (src != SRC_NONE);

endmodule

// File: rtl/sertx_shifter.sv
// Frame shift register. Bits change only on bit_tick. A loaded frame waits
// for the next tick; at the tick ending a frame the next one starts
// at once, so consecutive frames have no gap.
// Assumes: nxt_len >= 1 whenever nxt_valid is high.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int FW    = 13,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             nxt_valid,
    input  logic [FW-1:0]    nxt_bits,
    input  logic [CNT_W-1:0] nxt_len,
    input  kind_t            nxt_kind,
    output logic             take,
    output logic             frame_end,
    output logic             busy,
    output kind_t            cur_kind,
    output logic             line
);
    logic             busy_q;
    logic             line_q;
    logic [FW-1:0]    sh_q;
    logic [CNT_W-1:0] cnt_q;
    kind_t            kind_q;

    assign frame_end = busy_q && tick && (cnt_q == '0);
    assign take      = nxt_valid && (!busy_q || frame_end);
    assign busy      = busy_q;
    assign cur_kind  = kind_q;
    assign line      = line_q;

    // Load, shift and hand over frames on bit ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            line_q <= 1'b1;
            sh_q   <= '0;
            cnt_q  <= '0;
            kind_q <= K_NONE;
        end else if (!busy_q) begin
            if (nxt_valid) begin
                busy_q <= 1'b1;
                sh_q   <= nxt_bits;
                cnt_q  <= nxt_len;
                kind_q <= nxt_kind;
            end
        end else if (tick) begin
            if (cnt_q != '0) begin
                line_q <= sh_q[0];
                sh_q   <= sh_q >> 1;
                cnt_q  <= cnt_q - 1'b1;
            end else if (nxt_valid) begin
                line_q <= nxt_bits[0];
                sh_q   <= nxt_bits >> 1;
                cnt_q  <= nxt_len - 1'b1;
                kind_q <= nxt_kind;
            end else begin
                busy_q <= 1'b0;
                line_q <= 1'b1;
                kind_q <= K_NONE;
            end
        end
    end

    // R2: between ticks the line level never moves
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !tick |=> $stable(line_q));

    // R1: with no frame in progress the line rests high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> line_q);

endmodule

// File: rtl/sertx_flags.sv
// Buffer-empty and frame-done flags with the read-then-write clearing
// sequence, plus the gated interrupt requests.
// Assumes: the clear takes priority over a set in the same cycle.
module sertx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic wr,
    input  logic wr_buf,
    input  logic hold_taken,
    input  logic direct_taken,
    input  logic discard,
    input  logic frame_end,
    input  logic ie_empty,
    input  logic ie_done,
    output logic empty,
    output logic done,
    output logic irq_e,
    output logic irq_d
);
    logic armed_q;
    logic empty_q;
    logic done_q;

    // A status read arms the clear; any write uses up the arming
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (wr)      armed_q <= 1'b0;
        else if (stat_rd) armed_q <= 1'b1;
    end

    // Buffer-empty flag: cleared by an armed buffered write, set when the buffer drains
    always_ff @(posedge clk) begin
        if (!rst_n)                                      empty_q <= 1'b1;
        else if (wr_buf && armed_q)                      empty_q <= 1'b0;
        else if (hold_taken || direct_taken || discard)  empty_q <= 1'b1;
    end

    // Frame-done flag: cleared by an armed write, set at each frame end
    always_ff @(posedge clk) begin
        if (!rst_n)             done_q <= 1'b1;
        else if (wr && armed_q) done_q <= 1'b0;
        else if (frame_end)     done_q <= 1'b1;
    end

    assign empty = empty_q;
    assign done  = done_q;
    assign irq_e = empty_q && ie_empty;
    assign irq_d = done_q && ie_done;

    // R6: the buffer-empty flag falls only after an armed buffered write
    p_empty_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_q) |-> $past(armed_q && wr_buf));

    // R7: the frame-done flag rises only at a frame end
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(frame_end));

endmodule

// File: rtl/sertx_engine.sv
// Top of the buffered serial transmitter: holding register, frame
// selector, shift register and status flags.
// Assumes: bit_tick is a one-cycle strobe in the clk domain; control
// inputs are quasi-static register bits.
module sertx_engine
    import sertx_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int LIN_BRK_BITS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              stat_rd,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              cfg_nine,
    input  logic              cfg_bit9,
    input  logic              cfg_tx_en,
    input  logic              cfg_brk,
    input  logic              cfg_lin,
    input  logic              cfg_empty_ie,
    input  logic              cfg_done_ie,
    output logic              tx_out,
    output logic              flag_empty,
    output logic              flag_done,
    output logic              irq_empty,
    output logic              irq_done
);
    localparam int FW    = (DATA_W + 3 > LIN_BRK_BITS) ? DATA_W + 3 : LIN_BRK_BITS;
    localparam int CNT_W = $clog2(FW + 1);

    src_t              src;
    kind_t             nxt_kind;
    kind_t             cur_kind;
    logic              nxt_valid;
    logic [FW-1:0]     nxt_bits;
    logic [CNT_W-1:0]  nxt_len;
    logic              take;
    logic              fr_end;
    logic              busy;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              te_rise;
    logic              idle_pend;
    logic              direct_taken;
    logic              hold_taken;
    logic              idle_taken;
    logic              wr_buf;

    assign direct_taken = take && (src == SRC_DIRECT);
    assign hold_taken   = take && (src == SRC_HOLD);
    assign idle_taken   = take && (src == SRC_IDLE);
    assign wr_buf       = data_wr && !direct_taken;

    sertx_holdq #(.DATA_W(DATA_W)) u_holdq (
        .clk        (clk),
        .rst_n      (rst_n),
        .te         (cfg_tx_en),
        .wr_buf     (wr_buf),
        .wr_data    (wr_byte),
        .hold_taken (hold_taken),
        .idle_taken (idle_taken),
        .full       (hold_full),
        .data       (hold_data),
        .te_rise    (te_rise),
        .idle_pend  (idle_pend)
    );

    sertx_frame_pick #(
        .DATA_W       (DATA_W),
        .LIN_BRK_BITS (LIN_BRK_BITS),
        .FW           (FW),
        .CNT_W        (CNT_W)
    ) u_pick (
        .te_en     (cfg_tx_en),
        .busy      (busy),
        .cur_kind  (cur_kind),
        .brk       (cfg_brk),
        .lin       (cfg_lin),
        .m9        (cfg_nine),
        .t8        (cfg_bit9),
        .idle_pend (idle_pend),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .wr        (data_wr),
        .wr_data   (wr_byte),
        .src       (src),
        .nxt_valid (nxt_valid),
        .nxt_bits  (nxt_bits),
        .nxt_len   (nxt_len),
        .nxt_kind  (nxt_kind)
    );

    sertx_shifter #(.FW(FW), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .nxt_valid (nxt_valid),
        .nxt_bits  (nxt_bits),
        .nxt_len   (nxt_len),
        .nxt_kind  (nxt_kind),
        .take      (take),
        .frame_end (fr_end),
        .busy      (busy),
        .cur_kind  (cur_kind),
        .line      (tx_out)
    );

    sertx_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_rd      (stat_rd),
        .wr           (data_wr),
        .wr_buf       (wr_buf),
        .hold_taken   (hold_taken),
        .direct_taken (direct_taken),
        .discard      (te_rise),
        .frame_end    (fr_end),
        .ie_empty     (cfg_empty_ie),
        .ie_done      (cfg_done_ie),
        .empty        (flag_empty),
        .done         (flag_done),
        .irq_e        (irq_empty),
        .irq_d        (irq_done)
    );

    // R9: a break that ends with the control low hands over to a mark bit
    p_mark_after_brk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fr_end && cur_kind == K_BRK && !cfg_brk |=> busy && cur_kind == K_MARK);

    // R12: with transmit disabled only a mark bit may be loaded
    p_no_start_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take && !cfg_tx_en |-> src == SRC_MARK);

endmodule

// File: tb/sertx_engine_tb.sv
module sertx_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick;
    logic       stat_rd;
    logic       data_wr;
    logic [7:0] wr_byte;
    logic       cfg_nine, cfg_bit9, cfg_tx_en, cfg_brk, cfg_lin;
    logic       cfg_empty_ie, cfg_done_ie;
    logic       tx_out, flag_empty, flag_done, irq_empty, irq_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sertx_engine dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .stat_rd      (stat_rd),
        .data_wr      (data_wr),
        .wr_byte      (wr_byte),
        .cfg_nine     (cfg_nine),
        .cfg_bit9     (cfg_bit9),
        .cfg_tx_en    (cfg_tx_en),
        .cfg_brk      (cfg_brk),
        .cfg_lin      (cfg_lin),
        .cfg_empty_ie (cfg_empty_ie),
        .cfg_done_ie  (cfg_done_ie),
        .tx_out       (tx_out),
        .flag_empty   (flag_empty),
        .flag_done    (flag_done),
        .irq_empty    (irq_empty),
        .irq_done     (irq_done)
    );

    // Vector: {nine, bit9, word, frame length, expected frame bits LSB first}
    localparam int NV = 5;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'hA5, 4'd10, 13'h034A},
        {1'b1, 1'b1, 8'h3C, 4'd11, 13'h0678},
        {1'b1, 1'b0, 8'hFF, 4'd11, 13'h05FE},
        {1'b0, 1'b0, 8'h00, 4'd10, 13'h0200},
        {1'b0, 1'b0, 8'h01, 4'd10, 13'h0202}
    };

    // Bit strobe: one cycle high every four
    initial begin
        bit_tick = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Record the line level just after each of the next n ticks
    task automatic grab(input int n, output logic [31:0] v);
        v = '0;
        for (int k = 0; k < n; k++) begin
            do @(posedge clk); while (bit_tick !== 1'b1);
            #2;
            v[k] = tx_out;
        end
    endtask

    task automatic do_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); data_wr = 1'b1; wr_byte = d;
        @(negedge clk); data_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; stat_rd = 1'b0; data_wr = 1'b0; wr_byte = '0;
        cfg_nine = 1'b0; cfg_bit9 = 1'b0; cfg_tx_en = 1'b0; cfg_brk = 1'b0;
        cfg_lin = 1'b0; cfg_empty_ie = 1'b0; cfg_done_ie = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 line in reset", 32'(tx_out), 32'd1);
        check("R1 empty in reset", 32'(flag_empty), 32'd1);
        check("R1 done in reset", 32'(flag_done), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12: disabled transmitter holds the word and sends nothing
        do_read();
        do_write(8'h00);
        check("R12 held write clears empty", 32'(flag_empty), 32'd0);
        grab(12, v);
        check("R12 no frame while disabled", v, 32'h0000_0FFF);
        // R11: enable rise discards the held word and sends only an idle frame
        @(negedge clk); cfg_tx_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 discard sets empty", 32'(flag_empty), 32'd1);
        grab(22, v);
        check("R11 idle only, held word lost", v, 32'h003F_FFFF);

        // R11: idle frame goes before the first data word
        @(negedge clk); cfg_tx_en = 1'b0;
        repeat (2) @(negedge clk);
        do_read();
        @(negedge clk); cfg_tx_en = 1'b1; data_wr = 1'b1; wr_byte = 8'h00;
        @(negedge clk); data_wr = 1'b0;
        grab(21, v);
        check("R11 idle then data", v, 32'h0018_03FF);

        // R2 R3 R4 R6 R7: table of single frames
        cfg_done_ie = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [31:0] exp;
            cfg_nine = VEC[i][26];
            cfg_bit9 = VEC[i][25];
            do_read();
            do_write(VEC[i][24:17]);
            check("R6 armed write clears done", 32'(flag_done), 32'd0);
            check("R7 done irq low", 32'(irq_done), 32'd0);
            check("R4 direct load keeps empty", 32'(flag_empty), 32'd1);
            grab(int'(VEC[i][16:13]) + 1, v);
            exp = 32'(VEC[i][12:0]) | (32'd1 << VEC[i][16:13]);
            check(VEC[i][26] ? "R3 nine-bit frame" : "R2 eight-bit frame", v, exp);
            check("R7 done set at frame end", 32'(flag_done), 32'd1);
            check("R7 done irq high", 32'(irq_done), 32'd1);
        end
        cfg_nine = 1'b0; cfg_bit9 = 1'b0;

        // R5: buffered word follows with no gap
        cfg_empty_ie = 1'b1;
        do_read();
        do_write(8'h12);
        fork
            grab(21, v);
            begin
                do_read();
                do_write(8'h81);
                check("R5 buffered write clears empty", 32'(flag_empty), 32'd0);
                check("R7 empty irq low", 32'(irq_empty), 32'd0);
            end
        join
        check("R5 back-to-back frames", v, 32'h001C_0A24);
        check("R5 empty after transfer", 32'(flag_empty), 32'd1);
        check("R7 empty irq high", 32'(irq_empty), 32'd1);

        // R6: write without a prior status read leaves done set
        do_write(8'h33);
        check("R6 unarmed write keeps done", 32'(flag_done), 32'd1);
        grab(11, v);
        check("R6 unarmed frame still sent", v, 32'h0000_0666);

        // R8 R9: repeated breaks, mark bit, then the held word
        @(negedge clk); cfg_brk = 1'b1;
        @(negedge clk);
        fork
            grab(32, v);
            begin
                repeat (8) @(negedge clk);
                do_read();
                do_write(8'h55);
                repeat (50) @(negedge clk);
                cfg_brk = 1'b0;
            end
        join
        check("R8 R9 two breaks, mark, held word", v, 32'hD550_0000);

        // R8: nine-bit break length
        cfg_nine = 1'b1;
        @(negedge clk); cfg_brk = 1'b1;
        @(negedge clk);
        fork
            grab(13, v);
            begin repeat (10) @(negedge clk); cfg_brk = 1'b0; end
        join
        check("R8 eleven-bit break", v, 32'h0000_1800);

        // R10: bus-master break is 13 bits regardless of word length
        cfg_lin = 1'b1;
        @(negedge clk); cfg_brk = 1'b1;
        @(negedge clk);
        fork
            grab(15, v);
            begin repeat (10) @(negedge clk); cfg_brk = 1'b0; end
        join
        check("R10 thirteen-bit break", v, 32'h0000_6000);
        cfg_lin = 1'b0; cfg_nine = 1'b0;

        // R11: enable toggle mid-frame discards held word, idle follows
        do_read();
        do_write(8'h0F);
        fork
            grab(31, v);
            begin
                do_read();
                do_write(8'h00);
                cfg_tx_en = 1'b0;
                @(negedge clk); cfg_tx_en = 1'b1;
                repeat (2) @(negedge clk);
                check("R11 toggle empties buffer", 32'(flag_empty), 32'd1);
            end
        join
        check("R11 frame, idle, no held word", v, 32'h7FFF_FE1E);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule